// File: doc/BRIEF.md
# Nine-Bit UART Receiver with Address Filtering

This block receives asynchronous serial frames of 8 or 9 data bits. Each frame has one low start bit, data sent least significant bit first, and one stop bit. The serial line passes through a two-flop synchronizer. The line is sampled on a single-cycle oversampling tick that runs at 16 times the bit rate. Completed words go into a two-entry receive buffer. Each entry holds the data byte, the ninth bit and a framing-error mark, and the entry at the head of the buffer drives the outputs. Software pops the head entry with a one-cycle read strobe.

A four-bit control register holds the settings. It has a master enable, a nine-bit frame select, a continuous-receive enable and an address-filter enable. In 9-bit mode with the filter on, only words whose ninth bit is 1 are stored. All other words are discarded, which lets a node on a shared line listen for address words only. If a word arrives while the buffer is full, the word is lost and a sticky overrun flag is set. While that flag is set, reception is halted. The flag is cleared by writing the continuous-receive enable to 0.

Top module: `uart9_rx`

## Requirements
- R1: After reset the control register reads 0 and rx_irq, ovr_err, frm_err and rx_bit9 are all 0.
- R2: While the master enable (control bit 0) is 0, frames on the line are not received and rx_irq stays 0.
- R3: While the continuous-receive enable (control bit 2) is 0, frames are not received, even if the master enable is 1.
- R4: With the nine-bit select (control bit 1) at 0, a frame of 8 data bits sent least significant bit first appears on rx_data, and rx_bit9 reads 0.
- R5: With control bit 1 at 1, a frame carries 9 data bits. The ninth bit is presented on rx_bit9 alongside the low 8 bits on rx_data.
- R6: With control bits 1 and 3 both at 1, a word whose ninth bit is 0 is discarded without raising rx_irq. A word whose ninth bit is 1 is stored.
- R7: With control bit 1 at 0, the address filter (control bit 3) has no effect and every word is stored.
- R8: A word whose stop bit samples low is stored with frm_err at 1. frm_err is held per buffer entry, so the next good word reads frm_err 0 once it reaches the head.
- R9: The buffer holds two words in arrival order. rx_irq is 1 while at least one unread word is held, and each rd_pop removes the head word.
- R10: A word that completes while two words are held sets ovr_err and is lost. While ovr_err is 1 no further word is stored, and the held words stay readable. ovr_err stays at 1 until control bit 2 is written to 0.
- R11: A start edge whose line is high again at the middle of the start bit is rejected, and no word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial receive line, idles high |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control value: bit0 enable, bit1 nine-bit, bit2 continuous receive, bit3 address filter |
| rd_pop | input | 1 | Removes the head buffer entry |
| ctrl_q | output | 4 | Control register contents |
| rx_data | output | 8 | Head entry data byte |
| rx_bit9 | output | 1 | Head entry ninth bit |
| frm_err | output | 1 | Head entry framing error |
| ovr_err | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive interrupt, buffer not empty |

## Verification
The hardest state to reach is overrun. Two words must be left unread and a third full frame must finish while the buffer is full. After that, the halted receiver has to show that the held words are intact and that a further frame is ignored. The overrun test sends three frames back to back and then a fourth one. It drains the buffer and checks that the flag survives the drain. It then clears the continuous-receive enable and checks that reception resumes. The glitch test and the framing-error test likewise steer the line in the middle of a bit, at the start sample point and at the stop sample point.

// File: rtl/uart9_rx.sv
module uart9_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       ctrl_we,
  input  logic [3:0] ctrl_wdata,
  input  logic       rd_pop,
  output logic [3:0] ctrl_q,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       frm_err,
  output logic       ovr_err,
  output logic       rx_irq
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2 - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_WAITHI} st_t;

  st_t        st;
  logic [CW-1:0] cnt;
  logic [3:0] idx;
  logic [8:0] sh;
  logic [1:0] sync;
  logic [9:0] mem [2];
  logic       wp, rp;
  logic [1:0] fill;

  wire en    = ctrl_q[0];
  wire nine  = ctrl_q[1];
  wire cont  = ctrl_q[2];
  wire adet  = ctrl_q[3];
  wire rxs   = sync[1];
  wire active = en & cont & ~ovr_err;
  wire at_end = (cnt == CW'(OVS - 1));
  wire done   = active & tick & (st == S_STOP) & at_end;
  wire bit9   = nine & sh[8];
  wire accept = done & ~(nine & adet & ~sh[8]);
  wire full   = (fill == 2'd2);
  wire push   = accept & ~full;
  wire pop    = rd_pop & (fill != 2'd0);
  wire [3:0] last = nine ? 4'd8 : 4'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
    end else if (!active) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (tick) begin
      case (st)
        S_IDLE: if (!rxs) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (cnt == CW'(HALF)) begin
          cnt <= '0;
          idx <= '0;
          st  <= rxs ? S_IDLE : S_DATA;
        end else cnt <= cnt + 1'b1;
        S_DATA: if (at_end) begin
          cnt     <= '0;
          sh[idx] <= rxs;
          if (idx == last) st <= S_STOP;
          else idx <= idx + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_STOP: if (at_end) begin
          cnt <= '0;
          st  <= rxs ? S_IDLE : S_WAITHI;
        end else cnt <= cnt + 1'b1;
        S_WAITHI: if (rxs) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= 1'b0;
      rp   <= 1'b0;
      fill <= '0;
      mem[0] <= '0;
      mem[1] <= '0;
    end else begin
      if (push) begin
        mem[wp] <= {~rxs, bit9, sh[7:0]};
        wp      <= ~wp;
      end
      if (pop) rp <= ~rp;
      fill <= fill + {1'b0, push} - {1'b0, pop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_err <= 1'b0;
    else if (ctrl_we && !ctrl_wdata[2]) ovr_err <= 1'b0;
    else if (accept && full) ovr_err <= 1'b1;
  end

  wire [9:0] head = mem[rp];
  assign rx_irq  = (fill != 2'd0);
  assign rx_data = rx_irq ? head[7:0] : 8'h00;
  assign rx_bit9 = rx_irq & head[8];
  assign frm_err = rx_irq & head[9];
endmodule

module uart9_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_we,
  input logic [3:0] ctrl_wdata,
  input logic       rd_pop,
  input logic [3:0] ctrl_q,
  input logic [7:0] rx_data,
  input logic       ovr_err,
  input logic       rx_irq
);
  AST_OFF_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] && !rx_irq |=> !rx_irq); // R2
  AST_CONT_OFF_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[2] && !rx_irq |=> !rx_irq); // R3
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq && !rd_pop |=> rx_irq); // R9
  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq && !rd_pop |=> $stable(rx_data)); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err && !(ctrl_we && !ctrl_wdata[2]) |=> ovr_err); // R10
  AST_OVR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(rx_irq)); // R10
endmodule

bind uart9_rx uart9_rx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
  .rd_pop(rd_pop), .ctrl_q(ctrl_q), .rx_data(rx_data), .ovr_err(ovr_err),
  .rx_irq(rx_irq)
);

// File: tb/test_uart9_rx.sv
`timescale 1ns/1ps
module test_uart9_rx;
  logic clk = 0, rst_n = 0, tick = 1, rxd = 1, ctrl_we = 0, rd_pop = 0;
  logic [3:0] ctrl_wdata = 0;
  logic [3:0] ctrl_q;
  logic [7:0] rx_data;
  logic rx_bit9, frm_err, ovr_err, rx_irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  localparam logic [3:0] EN = 4'd1, NINE = 4'd2, CONT = 4'd4, ADET = 4'd8;

  uart9_rx i_uart9_rx (.clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .rd_pop(rd_pop), .ctrl_q(ctrl_q),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .frm_err(frm_err), .ovr_err(ovr_err),
    .rx_irq(rx_irq));

  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic pop();
    @(negedge clk); rd_pop = 1;
    @(negedge clk); rd_pop = 0;
  endtask

  task automatic send(input logic [8:0] d, input int n, input logic stopb);
    @(negedge clk); rxd = 0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = d[i];
      repeat (16) @(negedge clk);
    end
    rxd = stopb;
    repeat (16) @(negedge clk);
    rxd = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 ctrl", ctrl_q, 0);
    check("R1 irq", rx_irq, 0);
    check("R1 ovr", ovr_err, 0);
    check("R1 frm", frm_err, 0);
    check("R1 bit9", rx_bit9, 0);
  endtask

  task automatic t_disabled();
    wr(CONT);
    send(9'h055, 8, 1);
    check("R2 irq with enable off", rx_irq, 0);
    wr(EN);
    send(9'h055, 8, 1);
    check("R3 irq with cont off", rx_irq, 0);
  endtask

  task automatic t_8bit();
    wr(EN | CONT);
    send(9'h1A5, 8, 1);
    check("R4 irq", rx_irq, 1);
    check("R4 data", rx_data, 8'hA5);
    check("R4 bit9", rx_bit9, 0);
    pop();
    check("R4 irq after pop", rx_irq, 0);
  endtask

  task automatic t_9bit();
    wr(EN | CONT | NINE);
    send(9'h13C, 9, 1);
    check("R5 data", rx_data, 8'h3C);
    check("R5 bit9 one", rx_bit9, 1);
    pop();
    send(9'h0C3, 9, 1);
    check("R5 data2", rx_data, 8'hC3);
    check("R5 bit9 zero", rx_bit9, 0);
    pop();
  endtask

  task automatic t_addr();
    wr(EN | CONT | NINE | ADET);
    send(9'h012, 9, 1);
    check("R6 ninth 0 dropped", rx_irq, 0);
    send(9'h134, 9, 1);
    check("R6 ninth 1 irq", rx_irq, 1);
    check("R6 data", rx_data, 8'h34);
    check("R6 bit9", rx_bit9, 1);
    pop();
    wr(EN | CONT | ADET);
    send(9'h077, 8, 1);
    check("R7 irq 8-bit with filter", rx_irq, 1);
    check("R7 data", rx_data, 8'h77);
    pop();
  endtask

  task automatic t_ferr();
    wr(EN | CONT);
    send(9'h081, 8, 0);
    send(9'h042, 8, 1);
    check("R8 frm first", frm_err, 1);
    check("R8 data first", rx_data, 8'h81);
    pop();
    check("R8 frm second", frm_err, 0);
    check("R8 data second", rx_data, 8'h42);
    pop();
  endtask

  task automatic t_fifo();
    wr(EN | CONT);
    send(9'h011, 8, 1);
    send(9'h022, 8, 1);
    check("R9 irq", rx_irq, 1);
    check("R9 head first", rx_data, 8'h11);
    pop();
    check("R9 irq one left", rx_irq, 1);
    check("R9 head second", rx_data, 8'h22);
    pop();
    check("R9 irq empty", rx_irq, 0);
  endtask

  task automatic t_ovr();
    wr(EN | CONT);
    send(9'h001, 8, 1);
    send(9'h002, 8, 1);
    check("R10 no ovr at two", ovr_err, 0);
    send(9'h003, 8, 1);
    check("R10 ovr set", ovr_err, 1);
    send(9'h004, 8, 1);
    check("R10 head kept", rx_data, 8'h01);
    pop();
    check("R10 second kept", rx_data, 8'h02);
    pop();
    check("R10 nothing more stored", rx_irq, 0);
    check("R10 ovr sticky", ovr_err, 1);
    wr(EN);
    check("R10 ovr cleared", ovr_err, 0);
    wr(EN | CONT);
    send(9'h005, 8, 1);
    check("R10 resumed data", rx_data, 8'h05);
    pop();
  endtask

  task automatic t_glitch();
    wr(EN | CONT);
    @(negedge clk); rxd = 0;
    repeat (4) @(negedge clk);
    rxd = 1;
    repeat (200) @(negedge clk);
    check("R11 glitch rejected", rx_irq, 0);
    send(9'h0E7, 8, 1);
    check("R11 next frame ok", rx_data, 8'hE7);
    pop();
    check("R11 single word", rx_irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled();
    t_8bit();
    t_9bit();
    t_addr();
    t_ferr();
    t_fifo();
    t_ovr();
    t_glitch();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule